// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Qualifier

This block decides which pins of an 8-pin group hold a qualified interrupt. The pins are arranged in a configurable number of groups. Each pin carries four independent trigger mode bits: rising edge, falling edge, high level and low level. Each pin also has an enable bit. The block keeps a snapshot of the last known level of every group. It detects an edge by comparing the group's present levels against that snapshot. A level trigger qualifies a pin simply because the present level matches. The edge and level results are ORed. The combined vector is then gated by a raw status byte and by the enable bits.

A controller evaluates one group at a time. It presents the group number, the present levels and the raw status byte, and pulses the evaluate strobe. An optional update strobe copies the present levels into the snapshot. Used alone, the update strobe initializes the snapshot. Used together with an evaluation, it replaces the snapshot after that evaluation. The qualified byte appears on a registered output. A sequencer then reports its set bits one per handshake as global pin indices, lowest first. While events are outstanding, new evaluations and updates are not accepted.

Top module: `pin_irq_qualifier`

## Requirements
- R1: After reset, `pend_o` is 0, `ev_valid_o` is 0, and every mode bit, enable bit and snapshot bit is clear, so no evaluation can qualify a pin until configuration is written.
- R2: `upd_i` without `eval_i`, while idle, loads `lvl_i` into the snapshot of group `grp_i`. It leaves `pend_o` unchanged and raises no event.
- R3: A pin with its rising mode bit set qualifies when its snapshot bit is 0 and its present level is 1.
- R4: A pin with its falling mode bit set qualifies when its snapshot bit is 1 and its present level is 0.
- R5: An edge mode never qualifies a pin whose present level equals its snapshot bit.
- R6: A pin with its high mode bit set qualifies whenever its level is 1. A pin with its low mode bit set qualifies whenever its level is 0. The snapshot plays no part in either case.
- R7: Edge and level modes may be set together on one pin, and the pin qualifies if either term does.
- R8: A pin is reported pending only if its bit in `stat_i` and its enable bit are both 1.
- R9: A pin with no mode bit set is never pending, whatever its status and enable bits.
- R10: A configuration write updates the bits selected by `cfg_mask_i` to `cfg_data_i`, in group `cfg_grp_i`, and leaves every other bit unchanged. The target is chosen by `cfg_sel_i`: 0 rising, 1 falling, 2 high, 3 low, 4 enable. Codes 5 to 7 change nothing.
- R11: An evaluation with `upd_i` compares against the old snapshot and then stores `lvl_i`. An evaluation without `upd_i` leaves the snapshot as it was.
- R12: Pending bits are reported lowest bit first, with `ev_idx_o` = group × 8 + bit. `ev_valid_o` and `ev_idx_o` hold until `ev_ack_i`, and each acknowledge retires exactly one event.
- R13: While `ev_valid_o` is 1, `eval_i` and `upd_i` are ignored. Neither `pend_o` nor any snapshot changes.
- R14: An accepted evaluation updates `pend_o` on the next clock edge. If that byte is nonzero, the first event is valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_grp_i | input | GW | Group addressed by the write |
| cfg_sel_i | input | 3 | Target: 0 rise, 1 fall, 2 high, 3 low, 4 enable |
| cfg_mask_i | input | PINS | Bits to modify |
| cfg_data_i | input | PINS | New values for the modified bits |
| eval_i | input | 1 | Evaluate group `grp_i` |
| upd_i | input | 1 | Copy `lvl_i` into the snapshot of `grp_i` |
| grp_i | input | GW | Group being evaluated or updated |
| lvl_i | input | PINS | Present pin levels of the group |
| stat_i | input | PINS | Raw status byte of the group |
| pend_o | output | PINS | Qualified byte of the last accepted evaluation |
| ev_valid_o | output | 1 | An event is presented |
| ev_idx_o | output | IDX_W | Global pin index of the presented event |
| ev_ack_i | input | 1 | Consumer accepts the presented event |

## Verification
A corrupted mode, enable or snapshot bit does not show at the ports until that group is evaluated. It then appears on `pend_o` one cycle after the evaluation, and in the event stream as a missing or extra index. A snapshot fault may also stay hidden through an evaluation without update. It then shows up as an edge that repeats, or one that never fires, on the next evaluation. For that reason the stimulus evaluates each group repeatedly, both with and without the update strobe. A sequencer fault shows as a reordered, repeated or dropped index. It can also show as a presented event that changes while acknowledge is held low.

// File: rtl/irq_qual_pkg.sv
package irq_qual_pkg;
  localparam int SEL_W     = 3;
  localparam int NUM_MODES = 5;

  typedef enum logic [SEL_W-1:0] {
    SEL_RISE = 3'd0,
    SEL_FALL = 3'd1,
    SEL_HIGH = 3'd2,
    SEL_LOW  = 3'd3,
    SEL_EN   = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/irq_mode_bank.sv
module irq_mode_bank
  import irq_qual_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int GROUPS = 4,
  parameter int GW     = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [GW-1:0]                    wgrp,
  input  logic [SEL_W-1:0]                 sel,
  input  logic [PINS-1:0]                  mask,
  input  logic [PINS-1:0]                  data,
  input  logic [GW-1:0]                    rgrp,
  output logic [NUM_MODES-1:0][PINS-1:0]   mode_o
);
  // One small register file per mode; same write port shape for each.
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    logic [PINS-1:0] mem [GROUPS];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int g = 0; g < GROUPS; g++) mem[g] <= '0;
      end else if (we && sel == SEL_W'(m)) begin
        mem[wgrp] <= (mem[wgrp] & ~mask) | (data & mask);
      end
    end

    assign mode_o[m] = mem[rgrp];
  end
endmodule

// File: rtl/irq_snap_store.sv
module irq_snap_store #(
  parameter int PINS   = 8,
  parameter int GROUPS = 4,
  parameter int GW     = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [GW-1:0]   grp,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] rdata
);
  logic [PINS-1:0] snap [GROUPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < GROUPS; g++) snap[g] <= '0;
    end else if (we) begin
      snap[grp] <= wdata;
    end
  end

  // Read and write share the group address; the read sees the old value.
  assign rdata = snap[grp];
endmodule

// File: rtl/irq_qual_logic.sv
module irq_qual_logic #(
  parameter int PINS = 8
) (
  input  logic [PINS-1:0] lvl,
  input  logic [PINS-1:0] snap,
  input  logic [PINS-1:0] rise,
  input  logic [PINS-1:0] fall,
  input  logic [PINS-1:0] high,
  input  logic [PINS-1:0] low,
  input  logic [PINS-1:0] stat,
  input  logic [PINS-1:0] en,
  output logic [PINS-1:0] pend
);
  logic [PINS-1:0] moved;
  logic [PINS-1:0] edge_hit;
  logic [PINS-1:0] level_hit;

  always_comb begin
    moved     = lvl ^ snap;
    edge_hit  = moved & ((rise & lvl) | (fall & ~lvl));
    level_hit = (high & lvl) | (low & ~lvl);
    pend      = (edge_hit | level_hit) & stat & en;
  end
endmodule

// File: rtl/irq_event_seq.sv
module irq_event_seq #(
  parameter int PINS  = 8,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] base,
  input  logic [PINS-1:0]  vec,
  input  logic             ack,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int BW = (PINS > 1) ? $clog2(PINS) : 1;

  function automatic logic [BW-1:0] low_bit(input logic [PINS-1:0] v);
    logic [BW-1:0] r;
    r = '0;
    for (int i = PINS - 1; i >= 0; i--) begin
      if (v[i]) r = BW'(i);
    end
    return r;
  endfunction

  logic             vld_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] base_q;
  logic [PINS-1:0]  rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      rem_q  <= '0;
    end else if (load && !vld_q) begin
      vld_q  <= |vec;
      idx_q  <= base + IDX_W'(low_bit(vec));
      base_q <= base;
      rem_q  <= vec & (vec - 1'b1);
    end else if (vld_q && ack) begin
      if (|rem_q) begin
        idx_q <= base_q + IDX_W'(low_bit(rem_q));
        rem_q <= rem_q & (rem_q - 1'b1);
      end else begin
        vld_q <= 1'b0;
      end
    end
  end

  assign valid_o = vld_q;
  assign idx_o   = idx_q;

  // R12: presented event holds until acknowledged
  a_r12_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !ack) |=> (vld_q && $stable(idx_q)));

  // R12: within one burst the indices strictly increase
  a_r12_ascending: assert property (@(posedge clk) disable iff (rst)
    (vld_q && ack && (|rem_q)) |=> (vld_q && idx_q > $past(idx_q)));

  // R13: no new burst is loaded while one is outstanding
  a_r13_no_load_busy: assert property (@(posedge clk) disable iff (rst)
    (vld_q && load) |=> $stable(base_q));
endmodule

// File: rtl/pin_irq_qualifier.sv
module pin_irq_qualifier
  import irq_qual_pkg::*;
#(
  parameter int PINS   = 8,
  parameter int GROUPS = 4,
  localparam int GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int IDX_W = (GROUPS * PINS > 1) ? $clog2(GROUPS * PINS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we_i,
  input  logic [GW-1:0]    cfg_grp_i,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [PINS-1:0]  cfg_mask_i,
  input  logic [PINS-1:0]  cfg_data_i,
  input  logic             eval_i,
  input  logic             upd_i,
  input  logic [GW-1:0]    grp_i,
  input  logic [PINS-1:0]  lvl_i,
  input  logic [PINS-1:0]  stat_i,
  output logic [PINS-1:0]  pend_o,
  output logic             ev_valid_o,
  output logic [IDX_W-1:0] ev_idx_o,
  input  logic             ev_ack_i
);
  logic [NUM_MODES-1:0][PINS-1:0] modes;
  logic [PINS-1:0]                snap;
  logic [PINS-1:0]                pend_c;
  logic [PINS-1:0]                pend_q;
  logic                           eval_ok;
  logic                           upd_ok;
  logic [IDX_W-1:0]               base;

  assign eval_ok = eval_i && !ev_valid_o;
  assign upd_ok  = upd_i && !ev_valid_o;
  assign base    = IDX_W'(grp_i) * IDX_W'(PINS);

  irq_mode_bank #(.PINS(PINS), .GROUPS(GROUPS), .GW(GW)) u_modes (
    .clk    (clk),
    .rst    (rst),
    .we     (cfg_we_i),
    .wgrp   (cfg_grp_i),
    .sel    (cfg_sel_i),
    .mask   (cfg_mask_i),
    .data   (cfg_data_i),
    .rgrp   (grp_i),
    .mode_o (modes)
  );

  irq_snap_store #(.PINS(PINS), .GROUPS(GROUPS), .GW(GW)) u_snap (
    .clk   (clk),
    .rst   (rst),
    .we    (upd_ok),
    .grp   (grp_i),
    .wdata (lvl_i),
    .rdata (snap)
  );

  irq_qual_logic #(.PINS(PINS)) u_qual (
    .lvl  (lvl_i),
    .snap (snap),
    .rise (modes[int'(SEL_RISE)]),
    .fall (modes[int'(SEL_FALL)]),
    .high (modes[int'(SEL_HIGH)]),
    .low  (modes[int'(SEL_LOW)]),
    .stat (stat_i),
    .en   (modes[int'(SEL_EN)]),
    .pend (pend_c)
  );

  always_ff @(posedge clk) begin
    if (rst)          pend_q <= '0;
    else if (eval_ok) pend_q <= pend_c;
  end

  assign pend_o = pend_q;

  irq_event_seq #(.PINS(PINS), .IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .load    (eval_ok),
    .base    (base),
    .vec     (pend_c),
    .ack     (ev_ack_i),
    .valid_o (ev_valid_o),
    .idx_o   (ev_idx_o)
  );

  // R14: a nonzero qualified byte is accompanied by a presented event
  a_r14_event_follows: assert property (@(posedge clk) disable iff (rst)
    eval_ok |=> (ev_valid_o == (|pend_o)));

  // R8: pending bits never escape status and enable gating
  a_r8_gated: assert property (@(posedge clk) disable iff (rst)
    eval_ok |=> ((pend_o & ~($past(stat_i) & $past(modes[int'(SEL_EN)]))) == '0));

  // R9: a pin with no mode bits is never pending
  a_r9_no_mode: assert property (@(posedge clk) disable iff (rst)
    eval_ok |=> ((pend_o & ~($past(modes[int'(SEL_RISE)]) | $past(modes[int'(SEL_FALL)])
                            | $past(modes[int'(SEL_HIGH)]) | $past(modes[int'(SEL_LOW)]))) == '0));

  // R13: evaluation requests while busy leave the pending byte alone
  a_r13_ignored: assert property (@(posedge clk) disable iff (rst)
    (eval_i && ev_valid_o) |=> $stable(pend_o));
endmodule

// File: tb/tb_pin_irq_qualifier.sv
module tb_pin_irq_qualifier;
  localparam int PINS = 8;
  localparam int GROUPS = 4;
  localparam int GW = 2;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we_i = 1'b0;
  logic [GW-1:0] cfg_grp_i = '0;
  logic [2:0] cfg_sel_i = '0;
  logic [PINS-1:0] cfg_mask_i = '0, cfg_data_i = '0;
  logic eval_i = 1'b0, upd_i = 1'b0;
  logic [GW-1:0] grp_i = '0;
  logic [PINS-1:0] lvl_i = '0, stat_i = '0;
  logic [PINS-1:0] pend_o;
  logic ev_valid_o;
  logic [IDX_W-1:0] ev_idx_o;
  logic ev_ack_i = 1'b0;

  int checks = 0;
  int failures = 0;
  bit ack_en = 1'b1;
  bit done = 1'b0;
  int exp_q [$];

  // bench model of configuration and snapshot
  logic [PINS-1:0] m_mode [5][GROUPS];
  logic [PINS-1:0] m_snap [GROUPS];
  logic [PINS-1:0] last_pend = '0;

  pin_irq_qualifier #(.PINS(PINS), .GROUPS(GROUPS)) dut (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we_i), .cfg_grp_i(cfg_grp_i),
    .cfg_sel_i(cfg_sel_i), .cfg_mask_i(cfg_mask_i), .cfg_data_i(cfg_data_i),
    .eval_i(eval_i), .upd_i(upd_i), .grp_i(grp_i), .lvl_i(lvl_i),
    .stat_i(stat_i), .pend_o(pend_o), .ev_valid_o(ev_valid_o),
    .ev_idx_o(ev_idx_o), .ev_ack_i(ev_ack_i)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PINS-1:0] model_pend(input int g, input logic [PINS-1:0] l,
                                                 input logic [PINS-1:0] s);
    logic [PINS-1:0] moved;
    moved = l ^ m_snap[g];
    return ((moved & ((m_mode[0][g] & l) | (m_mode[1][g] & ~l)))
            | (m_mode[2][g] & l) | (m_mode[3][g] & ~l)) & s & m_mode[4][g];
  endfunction

  task automatic cfg(input int g, input int sel, input logic [PINS-1:0] mask,
                     input logic [PINS-1:0] data);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_grp_i = GW'(g); cfg_sel_i = 3'(sel);
    cfg_mask_i = mask; cfg_data_i = data;
    if (sel < 5) m_mode[sel][g] = (m_mode[sel][g] & ~mask) | (data & mask);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic wait_idle();
    forever begin
      @(negedge clk);
      #1;
      if (!ev_valid_o && exp_q.size() == 0) break;
    end
  endtask

  task automatic init_snap(input int g, input logic [PINS-1:0] l);
    @(negedge clk);
    upd_i = 1'b1; grp_i = GW'(g); lvl_i = l;
    m_snap[g] = l;
    @(negedge clk);
    upd_i = 1'b0;
    chk(pend_o == last_pend && !ev_valid_o, "R2 update-only no effect", pend_o, last_pend);
  endtask

  task automatic do_eval(input int g, input logic [PINS-1:0] l, input logic [PINS-1:0] s,
                         input bit upd, input bit ign, input bit wait_done, input string tag);
    logic [PINS-1:0] e;
    @(negedge clk);
    eval_i = 1'b1; upd_i = upd; grp_i = GW'(g); lvl_i = l; stat_i = s;
    if (ign) begin
      e = last_pend;
    end else begin
      e = model_pend(g, l, s);
      for (int b = 0; b < PINS; b++) if (e[b]) exp_q.push_back(g * PINS + b);
      if (upd) m_snap[g] = l;
      last_pend = e;
    end
    @(negedge clk);
    eval_i = 1'b0; upd_i = 1'b0;
    chk(pend_o == e, {tag, " R14 pending byte"}, pend_o, e);
    if (!ign) chk(ev_valid_o == (e != 0), {tag, " R14 first event valid"}, ev_valid_o, e != 0);
    if (wait_done) wait_idle();
  endtask

  // monitor: pops expected indices and acknowledges
  initial begin
    forever begin
      @(negedge clk);
      ev_ack_i = 1'b0;
      if (ev_valid_o && ack_en && !rst) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R12 unexpected event", ev_idx_o, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(ev_idx_o) == e, "R12 event index order", ev_idx_o, e);
        end
        ev_ack_i = 1'b1;
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 5; m++) for (int g = 0; g < GROUPS; g++) m_mode[m][g] = '0;
    for (int g = 0; g < GROUPS; g++) m_snap[g] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pend_o == 0, "R1 reset pending", pend_o, 0);
    chk(ev_valid_o == 0, "R1 reset valid", ev_valid_o, 0);
    do_eval(0, 8'hFF, 8'hFF, 0, 0, 1, "R1 nothing configured");

    // R2 initialize snapshots
    init_snap(0, 8'hF0);
    init_snap(1, 8'hAA);

    // R9 enabled, status set, no modes
    cfg(0, 4, 8'hFF, 8'hFF);
    do_eval(0, 8'h0F, 8'hFF, 0, 0, 1, "R9 no mode bits");

    // R10 masked writes; code 7 changes nothing
    cfg(0, 0, 8'h0F, 8'hFF);
    cfg(0, 0, 8'h03, 8'h00);
    cfg(0, 7, 8'hFF, 8'hFF);
    do_eval(0, 8'hFF, 8'hFF, 0, 0, 1, "R3 R10 rising");
    do_eval(0, 8'hFF, 8'hFF, 0, 0, 1, "R11 no update keeps snapshot");
    do_eval(0, 8'hFF, 8'hFF, 1, 0, 1, "R11 eval with update");
    do_eval(0, 8'hFF, 8'hFF, 0, 0, 1, "R5 R11 no change no edge");

    // R4 falling on group 1
    cfg(1, 1, 8'hFF, 8'hFF);
    cfg(1, 4, 8'hFF, 8'hFF);
    do_eval(1, 8'h00, 8'hFF, 1, 0, 1, "R4 R12 falling");

    // R6 level modes on group 2
    cfg(2, 2, 8'hFF, 8'h81);
    cfg(2, 3, 8'hFF, 8'h18);
    cfg(2, 4, 8'hFF, 8'hFF);
    do_eval(2, 8'h85, 8'hFF, 0, 0, 1, "R6 level");
    do_eval(2, 8'h85, 8'hFF, 1, 0, 1, "R6 level repeats");

    // R7 combined on group 3
    cfg(3, 0, 8'h01, 8'h01);
    cfg(3, 2, 8'h01, 8'h01);
    cfg(3, 1, 8'h02, 8'h02);
    cfg(3, 4, 8'hFF, 8'hFF);
    do_eval(3, 8'h01, 8'hFF, 1, 0, 1, "R7 edge and level");
    do_eval(3, 8'h01, 8'hFF, 0, 0, 1, "R7 level after edge");
    do_eval(3, 8'h00, 8'hFF, 0, 0, 1, "R7 neither");

    // R8 gating
    do_eval(2, 8'h85, 8'h0F, 0, 0, 1, "R8 status gate");
    cfg(2, 4, 8'h01, 8'h00);
    do_eval(2, 8'h85, 8'hFF, 0, 0, 1, "R8 enable gate");

    // R12 stall and R13 ignored requests
    ack_en = 1'b0;
    do_eval(2, 8'h85, 8'hFF, 0, 0, 0, "R12 stall");
    chk(ev_valid_o && ev_idx_o == 19, "R12 first held", ev_idx_o, 19);
    repeat (3) @(negedge clk);
    chk(ev_valid_o && ev_idx_o == 19, "R12 held without ack", ev_idx_o, 19);
    do_eval(1, 8'hFF, 8'h00, 1, 1, 0, "R13 busy ignored");
    chk(ev_idx_o == 19, "R13 event unchanged", ev_idx_o, 19);
    ack_en = 1'b1;
    wait_idle();
    // snapshot of group 1 must still be 00 from the falling test
    do_eval(1, 8'h00, 8'hFF, 0, 0, 1, "R13 update ignored");

    chk(exp_q.size() == 0, "R12 all events seen", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule